// File: doc/BRIEF.md
# Process Corner Tagging Sequencer

This block runs a fixed measurement routine over the die's on-chip device test structures and turns each reading into a process-corner code. It handles four device types in turn: low-voltage NMOS, then low-voltage PMOS, then high-voltage NMOS, then high-voltage PMOS. For each one it selects the structure and chooses the forced-current level. A high level is used to probe drive current and a low level to probe threshold voltage. It then waits a programmable settling time, fires a one-cycle conversion request at the ADC and waits for that ADC's one-cycle done pulse.

Each reading is compared against that step's own fast and slow limits and gives a 2-bit code. The codes are packed into an 8-bit tag register that the biasing logic reads once the tag is marked valid. A screening flag is raised when any step gives a corner that the per-step acceptance mask does not allow, or when the ADC does not answer within the timeout. The current source, the ADC and the test structures sit outside this block.

Top module: `corner_tag_seq`

## Requirements
- R1: Reset (synchronous, active high) gives busy=0, tag_valid=0, out_of_window=0, adc_start=0, and tag=8'hFF (every field reads 11, invalid). Asserting reset during a run aborts the run and restores these values.
- R2: After a start, struct_sel takes the values 0, 1, 2 and 3 in that order (LV NMOS, LV PMOS, HV NMOS, HV PMOS). Each value is issued one conversion. struct_sel does not change while adc_start is high.
- R3: While step s is active, cur_hi equals bit s of cur_level_cfg (1 = high forced current).
- R4: adc_start is a one-cycle pulse. In the first step it goes high settle_cycles+1 clock cycles after the clock edge that captures start.
- R5: The reading of step s is classified against fast_thr[s*ADC_W +: ADC_W] and slow_thr[s*ADC_W +: ADC_W]. Strictly above the fast limit gives 01 (fast). Otherwise, strictly below the slow limit gives 10 (slow). Otherwise the code is 00 (typical). A reading equal to either limit is therefore typical, and fast wins when the limits overlap.
- R6: The code of step s is stored in tag[2s+1:2s], so tag[1:0] holds LV NMOS and tag[7:6] holds HV PMOS.
- R7: tag_valid clears on the cycle after start is captured. It is set, with busy falling in the same cycle, only after the last step completes.
- R8: A start pulse while busy is high has no effect: the step in progress continues and the final tag is unchanged.
- R9: out_of_window is set if step s gives fast while allow_cfg[2s] is 0, or gives slow while allow_cfg[2s+1] is 0. It stays 0 when every result is allowed.
- R10: If no done pulse arrives within TIMEOUT cycles of a conversion request, that step's field becomes 11, out_of_window is set, and the sequence moves on to the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a tagging run |
| settle_cycles | input | SETTLE_W | Settling wait before each conversion |
| cur_level_cfg | input | N_STEPS | Per-step forced-current level select |
| fast_thr | input | N_STEPS*ADC_W | Packed per-step fast limits |
| slow_thr | input | N_STEPS*ADC_W | Packed per-step slow limits |
| allow_cfg | input | 2*N_STEPS | Per-step acceptance mask (fast ok, slow ok) |
| adc_done | input | 1 | One-cycle conversion-complete pulse |
| adc_data | input | ADC_W | Conversion result, valid with adc_done |
| struct_sel | output | STEP_W | Selected test structure |
| cur_hi | output | 1 | Forced-current level for the active step |
| adc_start | output | 1 | One-cycle conversion request |
| busy | output | 1 | Run in progress |
| tag | output | 2*N_STEPS | Packed corner codes |
| tag_valid | output | 1 | Tag complete and usable |
| out_of_window | output | 1 | Die flagged for screening |

## Verification
Several properties are checked on every cycle: the conversion request lasts a single cycle, the structure select holds steady while a request is out, a valid tag never coexists with busy and rises only at the end of a run, and a tag holding an invalid field always has the screening flag set. Other behaviour can only be shown by the bench scenarios. These are the step order and current level seen at each conversion, the exact settle latency, the classification at and around the limits including overlapping limits, the mask-driven screening, the timeout path with a silent ADC, and the rejection of a start that arrives mid-run.

// File: rtl/corner_pkg.sv
package corner_pkg;
  typedef enum logic [1:0] {
    CODE_TYP  = 2'b00,
    CODE_FAST = 2'b01,
    CODE_SLOW = 2'b10,
    CODE_BAD  = 2'b11
  } corner_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WAIT   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/corner_classify.sv
module corner_classify
  import corner_pkg::*;
#(
  parameter int ADC_W = 10
) (
  input  logic [ADC_W-1:0] reading,
  input  logic [ADC_W-1:0] fast_lim,
  input  logic [ADC_W-1:0] slow_lim,
  input  logic             fast_ok,
  input  logic             slow_ok,
  output corner_t          code,
  output logic             reject
);
  // Fast takes priority when the two limits overlap.
  always_comb begin
    if (reading > fast_lim)      code = CODE_FAST;
    else if (reading < slow_lim) code = CODE_SLOW;
    else                         code = CODE_TYP;
  end

  always_comb begin
    unique case (code)
      CODE_FAST: reject = !fast_ok;
      CODE_SLOW: reject = !slow_ok;
      default:   reject = 1'b0;
    endcase
  end
endmodule

// File: rtl/step_timer.sv
module step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/corner_tag_seq.sv
module corner_tag_seq
  import corner_pkg::*;
#(
  parameter int N_STEPS  = 4,
  parameter int ADC_W    = 10,
  parameter int SETTLE_W = 6,
  parameter int TIMEOUT  = 16,
  localparam int STEP_W  = (N_STEPS > 1) ? $clog2(N_STEPS) : 1,
  localparam int TAG_W   = 2 * N_STEPS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [SETTLE_W-1:0]      settle_cycles,
  input  logic [N_STEPS-1:0]       cur_level_cfg,
  input  logic [N_STEPS*ADC_W-1:0] fast_thr,
  input  logic [N_STEPS*ADC_W-1:0] slow_thr,
  input  logic [TAG_W-1:0]         allow_cfg,
  input  logic                     adc_done,
  input  logic [ADC_W-1:0]         adc_data,
  output logic [STEP_W-1:0]        struct_sel,
  output logic                     cur_hi,
  output logic                     adc_start,
  output logic                     busy,
  output logic [TAG_W-1:0]         tag,
  output logic                     tag_valid,
  output logic                     out_of_window
);
  localparam int TMO_W  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam int CNT_W  = (TMO_W > SETTLE_W) ? TMO_W : SETTLE_W;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);
  localparam logic [CNT_W-1:0]  TMO_LOAD  = CNT_W'(TIMEOUT - 1);

  seq_state_t          state;
  logic [STEP_W-1:0]   step;
  logic [ADC_W-1:0]    fast_arr [N_STEPS];
  logic [ADC_W-1:0]    slow_arr [N_STEPS];
  logic [1:0]          allow_arr[N_STEPS];
  logic                tmr_load, tmr_zero;
  logic [CNT_W-1:0]    tmr_val;
  corner_t             cls_code;
  logic                cls_reject;
  logic                last_step, step_end;
  logic [STEP_W-1:0]   step_nxt;

  // Unpack per-step configuration.
  for (genvar s = 0; s < N_STEPS; s++) begin : g_unpack
    assign fast_arr[s]  = fast_thr[s*ADC_W +: ADC_W];
    assign slow_arr[s]  = slow_thr[s*ADC_W +: ADC_W];
    assign allow_arr[s] = allow_cfg[2*s +: 2];
  end

  corner_classify #(.ADC_W(ADC_W)) u_cls (
    .reading (adc_data),
    .fast_lim(fast_arr[step]),
    .slow_lim(slow_arr[step]),
    .fast_ok (allow_arr[step][0]),
    .slow_ok (allow_arr[step][1]),
    .code    (cls_code),
    .reject  (cls_reject)
  );

  step_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_zero)
  );

  assign last_step = (step == LAST_STEP);
  assign step_end  = (state == ST_WAIT) && (adc_done || tmr_zero);
  assign step_nxt  = step + STEP_W'(1);

  // Timer reload: settle window on entry to a step, timeout on request.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state == ST_IDLE && start) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(settle_cycles);
    end else if (state == ST_SETTLE && tmr_zero) begin
      tmr_load = 1'b1;
      tmr_val  = TMO_LOAD;
    end else if (step_end && !last_step) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(settle_cycles);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      step          <= '0;
      cur_hi        <= 1'b0;
      adc_start     <= 1'b0;
      busy          <= 1'b0;
      tag           <= '1;
      tag_valid     <= 1'b0;
      out_of_window <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state         <= ST_SETTLE;
            step          <= '0;
            cur_hi        <= cur_level_cfg[0];
            busy          <= 1'b1;
            tag           <= '1;
            tag_valid     <= 1'b0;
            out_of_window <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (tmr_zero) begin
            adc_start <= 1'b1;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          adc_start <= 1'b0;
          if (adc_done) begin
            tag[2*step +: 2] <= cls_code;
            if (cls_reject) out_of_window <= 1'b1;
          end else if (tmr_zero) begin
            tag[2*step +: 2] <= CODE_BAD;
            out_of_window    <= 1'b1;
          end
          if (step_end) begin
            if (last_step) begin
              state     <= ST_IDLE;
              busy      <= 1'b0;
              tag_valid <= 1'b1;
            end else begin
              step   <= step_nxt;
              cur_hi <= cur_level_cfg[step_nxt];
              state  <= ST_SETTLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign struct_sel = step;

  // Checks
  logic tag_has_bad;
  always_comb begin
    tag_has_bad = 1'b0;
    for (int i = 0; i < N_STEPS; i++)
      if (tag[2*i +: 2] == 2'b11) tag_has_bad = 1'b1;
  end

  a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  a_r2_sel_hold: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> $stable(struct_sel));

  a_r7_valid_idle: assert property (@(posedge clk) disable iff (rst)
    tag_valid |-> !busy);

  a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(tag_valid) |-> $past(busy));

  a_r10_bad_flagged: assert property (@(posedge clk) disable iff (rst)
    (tag_valid && tag_has_bad) |-> out_of_window);

  a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || $rose(tag_valid)));
endmodule

// File: tb/corner_tag_seq_tb.sv
module corner_tag_seq_tb;
  localparam int CLK_P = 10;
  localparam int NS    = 4;
  localparam int AW    = 10;

  typedef struct packed {
    logic [AW-1:0] r0, r1, r2, r3;
    logic [7:0]    allow;
    logic [3:0]    mute;
    logic [3:0]    cur;
    logic [7:0]    exp_tag;
    logic          exp_oow;
  } vec_t;

  // limits: step s fast = 600+10s, slow = 400+10s
  localparam vec_t VECS [7] = '{
    '{10'd500, 10'd500, 10'd500, 10'd500, 8'h00, 4'b0000, 4'b0000, 8'h00, 1'b0},
    '{10'd700, 10'd500, 10'd300, 10'd800, 8'hFF, 4'b0000, 4'b1010, 8'h61, 1'b0},
    '{10'd700, 10'd500, 10'd300, 10'd800, 8'h00, 4'b0000, 4'b0101, 8'h61, 1'b1},
    '{10'd600, 10'd610, 10'd420, 10'd429, 8'h00, 4'b0000, 4'b1111, 8'h80, 1'b1},
    '{10'd500, 10'd500, 10'd500, 10'd500, 8'hFF, 4'b0010, 4'b0011, 8'h0C, 1'b1},
    '{10'd700, 10'd100, 10'd500, 10'd500, 8'h09, 4'b0000, 4'b1100, 8'h09, 1'b0},
    '{10'd500, 10'd611, 10'd500, 10'd500, 8'h08, 4'b0000, 4'b0110, 8'h04, 1'b1}
  };

  logic             clk = 0;
  logic             rst = 1;
  logic             start = 0;
  logic [5:0]       settle_cycles = '0;
  logic [NS-1:0]    cur_level_cfg = '0;
  logic [NS*AW-1:0] fast_thr = {10'd630, 10'd620, 10'd610, 10'd600};
  logic [NS*AW-1:0] slow_thr = {10'd430, 10'd420, 10'd410, 10'd400};
  logic [7:0]       allow_cfg = '0;
  logic             adc_done;
  logic [AW-1:0]    adc_data;
  logic [1:0]       struct_sel;
  logic             cur_hi, adc_start, busy, tag_valid, out_of_window;
  logic [7:0]       tag;

  logic [AW-1:0]    rd [NS];
  logic [3:0]       mute = '0;
  int               n_chk = 0;
  int               n_bad = 0;

  corner_tag_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .settle_cycles(settle_cycles),
    .cur_level_cfg(cur_level_cfg), .fast_thr(fast_thr), .slow_thr(slow_thr),
    .allow_cfg(allow_cfg), .adc_done(adc_done), .adc_data(adc_data),
    .struct_sel(struct_sel), .cur_hi(cur_hi), .adc_start(adc_start),
    .busy(busy), .tag(tag), .tag_valid(tag_valid), .out_of_window(out_of_window)
  );

  always #(CLK_P/2) clk = ~clk;

  // Behavioural ADC: answers 3 cycles after a request unless muted.
  logic [2:0] lat;
  always @(posedge clk) begin
    if (rst) begin
      lat      <= '0;
      adc_done <= 1'b0;
      adc_data <= '0;
    end else begin
      adc_done <= 1'b0;
      if (adc_start && !mute[struct_sel]) lat <= 3'd3;
      else if (lat != 0) begin
        lat <= lat - 3'd1;
        if (lat == 3'd1) begin
          adc_done <= 1'b1;
          adc_data <= rd[struct_sel];
        end
      end
    end
  end

  // Records select and current level at every conversion request.
  int   seq_n = 0;
  int   cur_bad = 0;
  logic [1:0] seq [64];
  always @(negedge clk) begin
    if (adc_start) begin
      if (seq_n < 64) seq[seq_n] = struct_sel;
      if (cur_hi !== cur_level_cfg[struct_sel]) cur_bad = cur_bad + 1;
      seq_n = seq_n + 1;
    end
  end

  initial begin
    #(CLK_P * 100000);
    $display("FAIL watchdog: run hung, act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_run(input int settle, input int exp_tag, input int exp_oow,
                        input int cur_cfg);
    int base, cb, n;
    base = seq_n;
    cb   = cur_bad;
    settle_cycles = 6'(settle);
    cur_level_cfg = 4'(cur_cfg);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    n = 1;
    chk("R7 valid cleared at start", int'(tag_valid), 0);
    chk("R7 busy at start", int'(busy), 1);
    while (!adc_start && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk("R4 settle latency", n, settle + 2);
    n = 0;
    while (!tag_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R7 valid and idle", int'({tag_valid, busy}), 2);
    chk("R5 R6 tag", int'(tag), exp_tag);
    chk("R9 R10 screen flag", int'(out_of_window), exp_oow);
    chk("R2 conversions", seq_n - base, 4);
    for (int k = 0; k < 4; k++) chk("R2 order", int'(seq[base + k]), k);
    chk("R3 current level", cur_bad - cb, 0);
  endtask

  task automatic load_vec(input vec_t v);
    rd[0] = v.r0; rd[1] = v.r1; rd[2] = v.r2; rd[3] = v.r3;
    allow_cfg = v.allow;
    mute      = v.mute;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) rd[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 valid", int'(tag_valid), 0);
    chk("R1 oow", int'(out_of_window), 0);
    chk("R1 adc_start", int'(adc_start), 0);
    chk("R1 tag", int'(tag), 8'hFF);
    rst = 0;
    @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      load_vec(VECS[v]);
      do_run(v, int'(VECS[v].exp_tag), int'(VECS[v].exp_oow), int'(VECS[v].cur));
    end

    // R8: start while busy is ignored
    load_vec(VECS[0]);
    settle_cycles = 6'd10;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (!(busy && struct_sel == 2'd2)) @(negedge clk);
    start = 1;
    @(negedge clk) start = 0;
    chk("R8 step kept", int'(struct_sel), 2);
    chk("R8 still busy", int'(busy), 1);
    while (!tag_valid) @(negedge clk);
    chk("R8 tag unchanged", int'(tag), 8'h00);

    // R5: overlapping limits on step 0, fast wins
    load_vec(VECS[0]);
    allow_cfg = 8'hFF;
    fast_thr[9:0] = 10'd300;
    slow_thr[9:0] = 10'd700;
    do_run(1, 8'h01, 0, 0);
    fast_thr[9:0] = 10'd600;
    slow_thr[9:0] = 10'd400;

    // R1: reset in mid-run aborts it
    load_vec(VECS[0]);
    settle_cycles = 6'd8;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (12) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk("R1 abort busy", int'(busy), 0);
    chk("R1 abort tag", int'(tag), 8'hFF);
    chk("R1 abort valid", int'(tag_valid), 0);
    rst = 0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule